// File: doc/BRIEF.md
# Register Write-Protection Unlock Sequencer

This block sits beside a register file and decides, for every bus write, which bits of the addressed register may change. A configurable table lists the guarded addresses, and each entry carries a bit mask of the guarded bits. While the block is locked, guarded bits are masked out of the write and the rest of the write goes through unchanged. Unguarded addresses and exempt bits are never affected.

Software unlocks the block by writing three bytes in a fixed order to one key register: 0x59, then 0x16, then 0x88. Reading the key register returns the lock status in bit 0. The register file applies `wr_allow_o` as a per-bit write enable in the same cycle as the write. Any later write to the key register locks the block again.

Top module: `wp_unlock_ctrl`

## Requirements
- R1: After reset, or after a reset that arrives in the middle of a key sequence, the block is locked (`unlocked_o` = 0 and key register bit 0 reads 0), and the sequence restarts at the first key byte.
- R2: Writing bytes 0x59, 0x16 and 0x88 (write data bits [7:0]) to the key address, in that order, sets `unlocked_o`. The flag is set on the clock edge that captures the third write.
- R3: A key byte that differs from the next expected byte returns the sequencer to its start, so a broken sequence never unlocks.
- R4: A mismatching key byte equal to 0x59 counts as the first byte of a new attempt.
- R5: Any write to the key address while unlocked locks the block again from the next cycle. That write does not count as a key byte.
- R6: Writes to other addresses between key bytes leave the sequence position unchanged.
- R7: While locked, a write to a fully guarded address gets `wr_allow_o` = 0 and `wr_drop_o` = 1.
- R8: While locked, only the guarded bits of a partly guarded register are masked. With the default table, offset 0x200 has every bit guarded except bit 6, and offset 0x208 has only bit 0 guarded.
- R9: A write to an address not in the table gets `wr_allow_o` = all ones and `wr_drop_o` = 0, whatever the lock state.
- R10: While unlocked, every write gets `wr_allow_o` = all ones and `wr_drop_o` = 0.
- R11: `rdata_o` returns the lock status in bit 0 with all other bits 0 when `addr_i` is the key address, and returns 0 for any other address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | Byte offset of the current bus access |
| wdata_i | input | DATA_W | Write data |
| we_i | input | 1 | Single-cycle write strobe |
| rdata_o | output | DATA_W | Read data for the key register (status in bit 0) |
| wr_allow_o | output | DATA_W | Per-bit write enable for the addressed register |
| wr_drop_o | output | 1 | Current write loses at least one guarded bit |
| unlocked_o | output | 1 | Protection is lifted |

## Verification
The bench targets the sequence corner cases. A wrong middle byte followed by the correct last byte would unlock a design that does not reset its pointer. A repeated 0x59 would leave locked a design that drops a mismatching byte without treating it as a new start. A relock write of 0x59 followed by 0x16 and 0x88 would unlock a design that counts the relock write as the first key byte. Unrelated writes between key bytes would break a design that resets on any bus write. Reset in mid-sequence would leave a stale pointer in a design whose reset does not reach the pointer. The masks are checked at a fully guarded register, at both partial registers, and at an unlisted address. This exposes a design with inverted masks, one that blocks whole registers, or one that lets the lock state leak into unguarded writes.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam int KEY_LEN = 3;
  localparam int KEY_W   = 8;
  // index 0 is the first byte expected
  localparam logic [KEY_LEN-1:0][KEY_W-1:0] KEY_SEQ = {8'h88, 8'h16, 8'h59};
  localparam int PTR_W = (KEY_LEN > 1) ? $clog2(KEY_LEN) : 1;
  typedef logic [PTR_W-1:0] key_ptr_t;
endpackage

// File: rtl/wp_key_seq.sv
module wp_key_seq
  import wp_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             key_wr_i,
  input  logic [KEY_W-1:0] key_byte_i,
  output logic             open_o
);
  localparam key_ptr_t LAST = key_ptr_t'(KEY_LEN - 1);

  key_ptr_t ptr_q, ptr_d;
  logic     open_q, open_d;

  always_comb begin
    ptr_d  = ptr_q;
    open_d = open_q;
    if (key_wr_i) begin
      if (open_q) begin
        open_d = 1'b0;          // any key write re-arms
        ptr_d  = '0;
      end else if (key_byte_i == KEY_SEQ[ptr_q]) begin
        if (ptr_q == LAST) begin
          open_d = 1'b1;
          ptr_d  = '0;
        end else begin
          ptr_d = ptr_q + key_ptr_t'(1);
        end
      end else if (key_byte_i == KEY_SEQ[0]) begin
        ptr_d = key_ptr_t'(1);  // restart counts as step one
      end else begin
        ptr_d = '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      open_q <= 1'b0;
    end else begin
      ptr_q  <= ptr_d;
      open_q <= open_d;
    end
  end

  assign open_o = open_q;
endmodule

// File: rtl/wp_prot_match.sv
module wp_prot_match #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int N_PROT = 6,
  parameter logic [N_PROT-1:0][ADDR_W-1:0] PROT_ADDR = '0,
  parameter logic [N_PROT-1:0][DATA_W-1:0] PROT_MASK = '0
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DATA_W-1:0] mask_o
);
  logic [N_PROT-1:0][DATA_W-1:0] hit_mask;

  for (genvar i = 0; i < N_PROT; i++) begin : g_ent
    assign hit_mask[i] = (addr_i == PROT_ADDR[i]) ? PROT_MASK[i] : '0;
  end

  always_comb begin
    mask_o = '0;
    for (int i = 0; i < N_PROT; i++) mask_o |= hit_mask[i];
  end
endmodule

// File: rtl/wp_unlock_ctrl.sv
module wp_unlock_ctrl
  import wp_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] KEY_ADDR = 12'h100,
  parameter int N_PROT = 6,
  parameter logic [N_PROT-1:0][ADDR_W-1:0] PROT_ADDR =
    {12'h208, 12'h200, 12'h024, 12'h018, 12'h010, 12'h008},
  parameter logic [N_PROT-1:0][DATA_W-1:0] PROT_MASK =
    {32'h0000_0001, 32'hFFFF_FFBF, 32'hFFFF_FFFF,
     32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] wr_allow_o,
  output logic              wr_drop_o,
  output logic              unlocked_o
);
  logic              key_hit;
  logic              key_wr;
  logic              open;
  logic [DATA_W-1:0] prot_mask;

  assign key_hit = (addr_i == KEY_ADDR);
  assign key_wr  = we_i && key_hit;

  wp_key_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .key_wr_i   (key_wr),
    .key_byte_i (wdata_i[KEY_W-1:0]),
    .open_o     (open)
  );

  wp_prot_match #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .N_PROT    (N_PROT),
    .PROT_ADDR (PROT_ADDR),
    .PROT_MASK (PROT_MASK)
  ) u_match (
    .addr_i (addr_i),
    .mask_o (prot_mask)
  );

  assign wr_allow_o = open ? '1 : ~prot_mask;
  assign wr_drop_o  = we_i && !open && (|prot_mask);
  assign rdata_o    = key_hit ? {{(DATA_W-1){1'b0}}, open} : '0;
  assign unlocked_o = open;
endmodule

// File: rtl/wp_unlock_chk.sv
module wp_unlock_chk
  import wp_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] KEY_ADDR = 12'h100
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              we_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [DATA_W-1:0] wr_allow_o,
  input logic              wr_drop_o,
  input logic              unlocked_o
);
  logic key_wr;
  assign key_wr = we_i && (addr_i == KEY_ADDR);

  // R2
  unlock_needs_last_key_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(unlocked_o) |-> $past(key_wr && wdata_i[KEY_W-1:0] == KEY_SEQ[KEY_LEN-1]));

  // R3
  wrong_byte_stays_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!unlocked_o && key_wr && wdata_i[KEY_W-1:0] != KEY_SEQ[KEY_LEN-1]) |=> !unlocked_o);

  // R5
  key_write_relocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unlocked_o && key_wr) |=> !unlocked_o);

  // R7
  drop_only_when_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_drop_o |-> (we_i && !unlocked_o));

  // R10
  open_allows_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unlocked_o |-> (wr_allow_o == '1 && !wr_drop_o));

  // R11
  status_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DATA_W-1:1] == '0);
endmodule

bind wp_unlock_ctrl wp_unlock_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .KEY_ADDR (KEY_ADDR)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .we_i       (we_i),
  .rdata_o    (rdata_o),
  .wr_allow_o (wr_allow_o),
  .wr_drop_o  (wr_drop_o),
  .unlocked_o (unlocked_o)
);

// File: tb/tb_wp_unlock_ctrl.sv
module tb_wp_unlock_ctrl;
  localparam int CLK_P = 10;
  localparam logic [11:0] KEY = 12'h100;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic        we_i = 1'b0;
  logic [31:0] rdata_o, wr_allow_o;
  logic        wr_drop_o, unlocked_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  wp_unlock_ctrl dut (
    .clk_i, .rst_ni, .addr_i, .wdata_i, .we_i,
    .rdata_o, .wr_allow_o, .wr_drop_o, .unlocked_o
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0; addr_i = '0; wdata_i = '0;
  endtask

  task automatic key3(logic [7:0] b0, logic [7:0] b1, logic [7:0] b2);
    wr(KEY, {24'h0, b0}); wr(KEY, {24'h0, b1}); wr(KEY, {24'h0, b2});
  endtask

  // reads key status at the port, away from the edge
  task automatic status(string req, logic exp);
    addr_i = KEY; we_i = 1'b0;
    #(CLK_P/4);
    check(req, rdata_o, {31'h0, exp});
    check(req, {31'h0, unlocked_o}, {31'h0, exp});
    addr_i = '0;
  endtask

  // drives a write and samples the qualifier before the capturing edge
  task automatic probe(string req, logic [11:0] a, logic [31:0] exp_allow, logic exp_drop);
    @(negedge clk_i);
    addr_i = a; wdata_i = 32'hA5A5_5A5A; we_i = 1'b1;
    #(CLK_P/4);
    check(req, wr_allow_o, exp_allow);
    check(req, {31'h0, wr_drop_o}, {31'h0, exp_drop});
    @(negedge clk_i);
    we_i = 1'b0; addr_i = '0;
  endtask

  task automatic t_reset;
    status("R1 reset state", 1'b0);
    addr_i = 12'h010;
    #1 check("R11 other addr reads zero", rdata_o, 32'h0);
  endtask

  task automatic t_locked_masks;
    probe("R7 full guard 0x010", 12'h010, 32'h0, 1'b1);
    probe("R7 full guard 0x024", 12'h024, 32'h0, 1'b1);
    probe("R8 bit6 exempt 0x200", 12'h200, 32'h0000_0040, 1'b1);
    probe("R8 bit0 only 0x208", 12'h208, 32'hFFFF_FFFE, 1'b1);
    probe("R9 unlisted locked", 12'h300, 32'hFFFF_FFFF, 1'b0);
    status("R6 probes left lock", 1'b0);
  endtask

  task automatic t_unlock;
    key3(8'h59, 8'h16, 8'h88);
    status("R2 clean sequence", 1'b1);
    probe("R10 open 0x010", 12'h010, 32'hFFFF_FFFF, 1'b0);
    probe("R10 open 0x208", 12'h208, 32'hFFFF_FFFF, 1'b0);
    probe("R9 unlisted open", 12'h300, 32'hFFFF_FFFF, 1'b0);
    status("R11 status exact when open", 1'b1);
    wr(KEY, 32'h0);
    status("R5 relock", 1'b0);
  endtask

  task automatic t_broken;
    wr(KEY, 32'h59); wr(KEY, 32'h16); wr(KEY, 32'h00); wr(KEY, 32'h88);
    status("R3 wrong middle byte", 1'b0);
    key3(8'h16, 8'h88, 8'h16);
    status("R3 starts mid key", 1'b0);
    wr(KEY, 32'h88);
    status("R3 last byte alone", 1'b0);
    wr(KEY, 32'h59); wr(KEY, 32'h88);
    status("R3 skipped byte", 1'b0);
    key3(8'h59, 8'h16, 8'h88);
    status("R3 recovers after errors", 1'b1);
    wr(KEY, 32'h77);
    status("R5 relock any value", 1'b0);
  endtask

  task automatic t_restart;
    wr(KEY, 32'h59); key3(8'h59, 8'h16, 8'h88);
    status("R4 repeated first byte", 1'b1);
    wr(KEY, 32'h59);
    status("R5 relock with first byte", 1'b0);
    wr(KEY, 32'h16); wr(KEY, 32'h88);
    status("R5 relock write not a key step", 1'b0);
    wr(KEY, 32'h59); wr(KEY, 32'h16); key3(8'h59, 8'h16, 8'h88);
    status("R4 restart at third step", 1'b1);
    wr(KEY, 32'h0);
  endtask

  task automatic t_interleave;
    wr(KEY, 32'h59); wr(12'h010, 32'h88);
    wr(KEY, 32'h16); wr(12'h300, 32'h0);
    wr(KEY, 32'h88);
    status("R6 unrelated writes between bytes", 1'b1);
    wr(KEY, 32'h0);
  endtask

  task automatic t_mid_reset;
    wr(KEY, 32'h59); wr(KEY, 32'h16);
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
    wr(KEY, 32'h88);
    status("R1 reset clears pointer", 1'b0);
  endtask

  initial begin
    #(CLK_P * 50000);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_locked_masks();
    t_unlock();
    t_broken();
    t_restart();
    t_interleave();
    t_mid_reset();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule